// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block gates a bank of peripheral clocks, in groups of 32, behind a small register window. Software switches a clock on by writing a one to its bit in the group's set register, and off by writing a one to its bit in the group's clear register. Bits written as zero leave their clocks alone, so no read-modify-write is needed and no lock is needed either.

Each clock has a requested state, held in a request flop, and an applied state, held in a status flop. The status flop takes the requested value only after a fixed number of clock cycles. This models the handshake into the gated domain, and software polls the status register until it matches. Each clock's gate-enable output is its status bit; the actual glitch-free gate cells sit outside the block.

A clock number N belongs to group N/32 at bit N mod 32. The reset value of each request and status register is a parameter, so that clocks such as a memory controller's can come up running.

Top module: `clkgate_ctrl`

## Requirements
- R1: Group g occupies four 32-bit registers at byte offsets 0x24+0x10*g (set), +0x4 (clear), +0x8 (request) and +0xC (status). Clock number N is bit N mod 32 of group N/32.
- R2: A write to a set register turns on the request bit of every bit written as 1. Request bits written as 0 keep their value.
- R3: A write to a clear register turns off the request bit of every bit written as 1. Request bits written as 0 keep their value.
- R4: Reading the set, clear or request offset of a group returns that group's request register.
- R5: A status bit does not change at the clock edge that accepts a write touching it. It takes the bit's request value exactly SYNC_LAT rising edges after that write (default 3), and it holds its value during the edges in between.
- R6: A new write that touches a bit while that bit is still waiting restarts its delay from the new write. Bits not touched by the new write keep their own timing.
- R7: Each gate-enable output bit equals the status bit of the same clock number. Reading a status offset returns those bits.
- R8: After reset the request and status registers hold REQ_RESET and STS_RESET. By default only clock 2 (group 0, bit 2) is on.
- R9: Reads of any offset outside R1's map, including misaligned ones, return zero. Writes to those offsets, and writes to the request and status offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W (8) | Byte offset for the read or write |
| wdata | input | GROUP_W (32) | Write data; a 1 selects that clock |
| rdata | output | GROUP_W (32) | Read data for addr (combinational) |
| gate_en | output | NUM_GROUPS*GROUP_W (64) | Gate enable per clock |

## Verification
A single-bit walk over all 64 clock numbers is driven through the set registers. It separates the two group windows and each bit position, and at every edge of the delay it shows whether the status lag is exact. Alternating multi-bit clear patterns, written in successive cycles to both groups, show that zero bits leave their neighbours alone and that the two groups are independent. An overlapping rewrite of one bit while another bit from the same first write is still waiting separates a per-bit restart from a shared or a missing one. All-zero writes, writes to read-only and unmapped offsets, and reads of unmapped or misaligned offsets show that no stray decode reaches the registers.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Register kinds within one group window, in address order
    typedef enum logic [1:0] {
        KIND_SET = 2'd0,
        KIND_CLR = 2'd1,
        KIND_REQ = 2'd2,
        KIND_STS = 2'd3
    } reg_kind_e;

    localparam int unsigned WIN_FIRST  = 32'h24;  // first group window
    localparam int unsigned WIN_STRIDE = 32'h10;  // bytes per group window
    localparam int unsigned REG_STEP   = 32'h4;   // bytes per register

    function automatic int unsigned reg_offset(input int unsigned grp, input reg_kind_e kind);
        return WIN_FIRST + grp * WIN_STRIDE + int'(kind) * REG_STEP;
    endfunction

endpackage

// File: rtl/clkgate_regdec.sv
module clkgate_regdec
    import clkgate_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_W    = 32,
    parameter int ADDR_W     = 8,
    localparam int NCLK      = NUM_GROUPS * GROUP_W
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [GROUP_W-1:0] wdata,
    input  logic [NCLK-1:0]    req_all,
    input  logic [NCLK-1:0]    sts_all,
    output logic [NCLK-1:0]    set_all,
    output logic [NCLK-1:0]    clr_all,
    output logic [GROUP_W-1:0] rdata
);

    always_comb begin
        set_all = '0;
        clr_all = '0;
        rdata   = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr == ADDR_W'(reg_offset(g, KIND_SET))) begin
                rdata = req_all[g*GROUP_W +: GROUP_W];
                if (wr_en) set_all[g*GROUP_W +: GROUP_W] = wdata;
            end
            if (addr == ADDR_W'(reg_offset(g, KIND_CLR))) begin
                rdata = req_all[g*GROUP_W +: GROUP_W];
                if (wr_en) clr_all[g*GROUP_W +: GROUP_W] = wdata;
            end
            if (addr == ADDR_W'(reg_offset(g, KIND_REQ))) begin
                rdata = req_all[g*GROUP_W +: GROUP_W];
            end
            if (addr == ADDR_W'(reg_offset(g, KIND_STS))) begin
                rdata = sts_all[g*GROUP_W +: GROUP_W];
            end
        end
    end

endmodule

// File: rtl/clkgate_group.sv
module clkgate_group #(
    parameter int               GROUP_W  = 32,
    parameter int               SYNC_LAT = 3,
    parameter logic [GROUP_W-1:0] REQ_INIT = '0,
    parameter logic [GROUP_W-1:0] STS_INIT = '0,
    localparam int              CNT_W    = $clog2(SYNC_LAT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] set_mask,
    input  logic [GROUP_W-1:0] clr_mask,
    output logic [GROUP_W-1:0] req_o,
    output logic [GROUP_W-1:0] sts_o
);

    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(SYNC_LAT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    typedef struct packed {
        logic [GROUP_W-1:0]            req;
        logic [GROUP_W-1:0]            sts;
        logic [GROUP_W-1:0][CNT_W-1:0] wait_cnt;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < GROUP_W; i++) begin
            if (clr_mask[i]) begin
                st_d.req[i] = 1'b0;
            end else if (set_mask[i]) begin
                st_d.req[i] = 1'b1;
            end
            if (set_mask[i] || clr_mask[i]) begin
                st_d.wait_cnt[i] = LAT_C;
            end else if (st_q.wait_cnt[i] != '0) begin
                st_d.wait_cnt[i] = st_q.wait_cnt[i] - ONE_C;
                if (st_q.wait_cnt[i] == ONE_C) begin
                    st_d.sts[i] = st_q.req[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req      <= REQ_INIT;
            st_q.sts      <= STS_INIT;
            st_q.wait_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;
    assign sts_o = st_q.sts;

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_W    = 32,
    parameter int ADDR_W     = 8,
    parameter int SYNC_LAT   = 3,
    parameter logic [NUM_GROUPS*GROUP_W-1:0] REQ_RESET = 'h4,
    parameter logic [NUM_GROUPS*GROUP_W-1:0] STS_RESET = 'h4,
    localparam int NCLK = NUM_GROUPS * GROUP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [GROUP_W-1:0] wdata,
    output logic [GROUP_W-1:0] rdata,
    output logic [NCLK-1:0]    gate_en
);

    logic [NCLK-1:0] set_all;
    logic [NCLK-1:0] clr_all;
    logic [NCLK-1:0] req_all;
    logic [NCLK-1:0] sts_all;

    clkgate_regdec #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_W    (GROUP_W),
        .ADDR_W     (ADDR_W)
    ) regdec_i (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .req_all (req_all),
        .sts_all (sts_all),
        .set_all (set_all),
        .clr_all (clr_all),
        .rdata   (rdata)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        clkgate_group #(
            .GROUP_W  (GROUP_W),
            .SYNC_LAT (SYNC_LAT),
            .REQ_INIT (REQ_RESET[g*GROUP_W +: GROUP_W]),
            .STS_INIT (STS_RESET[g*GROUP_W +: GROUP_W])
        ) grp_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_all[g*GROUP_W +: GROUP_W]),
            .clr_mask (clr_all[g*GROUP_W +: GROUP_W]),
            .req_o    (req_all[g*GROUP_W +: GROUP_W]),
            .sts_o    (sts_all[g*GROUP_W +: GROUP_W])
        );
    end

    assign gate_en = sts_all;

endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk
    import clkgate_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GROUP_W    = 32,
    parameter int ADDR_W     = 8,
    localparam int NCLK      = NUM_GROUPS * GROUP_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [GROUP_W-1:0] wdata,
    input logic [GROUP_W-1:0] rdata,
    input logic [NCLK-1:0]    gate_en
);

    logic addr_mapped;
    always_comb begin
        addr_mapped = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            for (int k = 0; k < 4; k++) begin
                if (addr == ADDR_W'(reg_offset(g, reg_kind_e'(k)))) addr_mapped = 1'b1;
            end
        end
    end

    // R9: unmapped offsets read as zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped |-> rdata == '0);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(reg_offset(g, KIND_SET));
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(reg_offset(g, KIND_CLR));
        localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(reg_offset(g, KIND_STS));

        // R5: bits touched by a set write do not move at the accepting edge
        assert_set_no_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == SET_A) |=>
            (((gate_en[g*GROUP_W +: GROUP_W] ^ $past(gate_en[g*GROUP_W +: GROUP_W]))
              & $past(wdata)) == '0));

        // R5: same for a clear write
        assert_clr_no_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CLR_A) |=>
            (((gate_en[g*GROUP_W +: GROUP_W] ^ $past(gate_en[g*GROUP_W +: GROUP_W]))
              & $past(wdata)) == '0));

        // R7: status read matches the gate outputs
        assert_status_is_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == STS_A) |-> rdata == gate_en[g*GROUP_W +: GROUP_W]);
    end

endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W),
    .ADDR_W     (ADDR_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .gate_en (gate_en)
);

// File: tb/clkgate_ctrl_tb_top.sv
module clkgate_ctrl_tb_top;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [63:0] gate_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    clkgate_ctrl #(.SYNC_LAT(LAT)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .gate_en (gate_en)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] win(input int g, input int k);
        return 8'(32'h24 + g * 32'h10 + k * 4);
    endfunction

    // called just after a falling edge; samples in the low phase
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] exp_req;
        logic [63:0] exp_sts;
        logic [63:0] nxt;
        logic [31:0] d;

        rst_n = 1'b0;
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset values
        exp_req = 64'h4;
        exp_sts = 64'h4;
        check("R8 gate_en after reset", gate_en, exp_sts);
        rd(win(0, 2), d); check("R8 group0 request", {32'h0, d}, 64'h4);
        rd(win(1, 2), d); check("R8 group1 request", {32'h0, d}, 64'h0);
        rd(win(0, 3), d); check("R8 group0 status", {32'h0, d}, 64'h4);
        rd(win(1, 3), d); check("R8 group1 status", {32'h0, d}, 64'h0);

        // R1 R2 R4 R5 R7: walk one set bit over every clock number
        for (int n = 0; n < 64; n++) begin
            int g;
            int b;
            g = n / 32;
            b = n % 32;
            wr(win(g, 0), 32'h1 << b);
            nxt = exp_req | (64'h1 << n);
            check("R5 status held at write edge", gate_en, exp_sts);
            rd(win(g, 2), d); check("R2 request after set", {32'h0, d}, {32'h0, nxt[g*32 +: 32]});
            rd(win(g, 0), d); check("R4 set offset reads request", {32'h0, d}, {32'h0, nxt[g*32 +: 32]});
            rd(win(g, 1), d); check("R4 clear offset reads request", {32'h0, d}, {32'h0, nxt[g*32 +: 32]});
            for (int j = 1; j < LAT; j++) begin
                @(negedge clk);
                check("R5 status held inside delay", gate_en, exp_sts);
            end
            @(negedge clk);
            exp_req = nxt;
            exp_sts = nxt;
            check("R7 gate_en after delay", gate_en, exp_sts);
            rd(win(g, 3), d); check("R1 status read of group", {32'h0, d}, {32'h0, exp_sts[g*32 +: 32]});
        end

        // R3: multi-bit clear patterns, both groups back to back
        wr(win(0, 1), 32'hA5A5_A5A5);
        wr(win(1, 1), 32'h0F0F_0F0F);
        check("R5 gate_en still on after clears", gate_en, exp_sts);
        exp_req = ~{32'h0F0F_0F0F, 32'hA5A5_A5A5};
        rd(win(0, 2), d); check("R3 group0 request after clear", {32'h0, d}, {32'h0, exp_req[31:0]});
        rd(win(1, 2), d); check("R3 group1 request after clear", {32'h0, d}, {32'h0, exp_req[63:32]});
        repeat (LAT + 1) @(negedge clk);
        exp_sts = exp_req;
        check("R3 gate_en after clear delay", gate_en, exp_sts);

        // R2: all-zero set write changes nothing
        wr(win(0, 0), 32'h0);
        wr(win(1, 1), 32'h0);
        repeat (LAT + 1) @(negedge clk);
        check("R2 zero write leaves gates", gate_en, exp_sts);
        rd(win(0, 2), d); check("R2 zero write leaves request", {32'h0, d}, {32'h0, exp_req[31:0]});

        // R6: set bits 0 and 2, then set bit 0 again two edges later
        wr(win(0, 0), 32'h5);
        for (int e = 1; e <= LAT + 2; e++) begin
            logic [63:0] ex;
            @(negedge clk);
            wr_en = (e == 1);
            addr  = win(0, 0);
            wdata = 32'h1;
            ex = exp_sts;
            ex[2] = (e >= LAT);
            ex[0] = (e >= LAT + 2);
            check("R6 restart affects only rewritten bit", gate_en, ex);
        end
        wr_en = 1'b0;
        exp_req = exp_req | 64'h5;
        exp_sts = exp_req;

        // R9: unmapped and read-only offsets
        rd(8'h00, d); check("R9 read 0x00", {32'h0, d}, 64'h0);
        rd(8'h20, d); check("R9 read 0x20", {32'h0, d}, 64'h0);
        rd(8'h44, d); check("R9 read 0x44", {32'h0, d}, 64'h0);
        rd(8'h26, d); check("R9 misaligned read", {32'h0, d}, 64'h0);
        rd(8'hFC, d); check("R9 read 0xFC", {32'h0, d}, 64'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h25, 32'hFFFF_FFFF);
        wr(win(0, 2), 32'hFFFF_FFFF);
        wr(win(1, 3), 32'hFFFF_FFFF);
        repeat (LAT + 1) @(negedge clk);
        check("R9 ignored writes leave gates", gate_en, exp_sts);
        rd(win(0, 2), d); check("R9 group0 request unchanged", {32'h0, d}, {32'h0, exp_req[31:0]});
        rd(win(1, 2), d); check("R9 group1 request unchanged", {32'h0, d}, {32'h0, exp_req[63:32]});

        finish_run();
    end

endmodule